// File: doc/BRIEF.md
# Eight-Channel Addressable Output Latch

This block keeps one on/off bit for each of eight load-driver channels. A channel is picked by a 3-bit binary address and written from a single data line while an active-low select is held low. While select stays low the picked bit tracks the data line on every clock, so software or a timer can pulse-width modulate one channel just by toggling data. An active-low clear empties every bit. An active-high enable blanks all channels together without touching the stored bits. The block drives an "on" vector and its active-low open-drain style complement.

Every control input is brought through a two-flop synchronizer on the system clock, so the pins may be driven asynchronously. The synchronizer reset values model the state of lines that are left open. Select reads low, clear reads low, enable reads low, and data and address read high. After reset every channel is therefore off and blanked.

Top module: `chan_out_latch`

## Requirements
- R1: While and right after the synchronous reset `rst` is high, `chan_on` is all zeros and `chan_off_n` is all ones.
- R2: Address bit 2 is the most significant and bit 0 the least; address code k (0..7) selects channel k, that is bit k of `chan_on`.
- R3: While `sel_n` is low and clear is inactive, the addressed bit follows `wr_data` on every clock (1 = on, 0 = off), so a toggling data line is reproduced on the channel.
- R4: While `sel_n` is high, changes on `wr_addr` and `wr_data` have no effect and every bit keeps its value.
- R5: A write changes only the addressed bit; all other bits keep their values.
- R6: While `clr_n` is low, every bit is forced off whatever `sel_n`, `wr_addr` and `wr_data` do; clear wins over a simultaneous write.
- R7: While `out_en` is low, all outputs read off, and the stored bits are kept: raising `out_en` again brings back the earlier pattern.
- R8: While `out_en` is high, `chan_on` equals the stored bits.
- R9: If the address changes while `sel_n` stays low, each newly addressed bit receives the data, so several channels can be set or cleared without toggling select.
- R10: `chan_off_n` is always the bitwise complement of `chan_on`.
- R11: A write reaches `chan_on` on the fourth rising edge after the input change (two synchronizer stages, the latch, the output register); a change of `out_en` reaches the outputs on the third edge.
- R12: In the first cycle in which the synchronized clear reads inactive again, no write is made; a held write lands one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Write select, active low, asynchronous |
| clr_n | input | 1 | Clear of all bits, active low, asynchronous |
| out_en | input | 1 | Output enable, active high, asynchronous |
| wr_data | input | 1 | Data for the addressed bit |
| wr_addr | input | ADDR_W (3) | Channel address, bit 2 most significant |
| chan_on | output | NUM_CH (8) | Registered channel-on vector |
| chan_off_n | output | NUM_CH (8) | Registered active-low equivalent (1 = off) |

## Verification
The bench uses the default build: eight channels, a 3-bit address and two synchronizer stages. With these values every address code, the Gray-order sweep under a held select and the exact edge count of the write, enable and clear-release paths can be driven directly. Several hundred random steps mix select, clear, enable, data and address against a bench model of the stored bits.

// File: rtl/olatch_pkg.sv
package olatch_pkg;
  // Synchronized control inputs
  typedef struct packed {
    logic sel_n;
    logic clr_n;
    logic oe;
    logic din;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Values of open input lines: select low, clear low, enable low, data high
  localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b0, clr_n: 1'b0, oe: 1'b0, din: 1'b1};
endpackage

// File: rtl/olatch_sync.sv
module olatch_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/olatch_dec.sv
module olatch_dec #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [NUM_CH-1:0] sel
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] CODE = ADDR_W'(i);
    assign sel[i] = en && (addr == CODE);
  end
endmodule

// File: rtl/olatch_bank.sv
module olatch_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              din,
  input  logic [NUM_CH-1:0] sel,
  output logic [NUM_CH-1:0] bits_q,
  output logic              clr_hist
);
  logic wr_ok;

  // Clear seen inactive for two cycles in a row before a write may land
  always_ff @(posedge clk) begin
    if (rst) clr_hist <= 1'b0;
    else     clr_hist <= clr_n;
  end

  assign wr_ok = clr_n && clr_hist;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || !clr_n)        bits_q[i] <= 1'b0;
      else if (wr_ok && sel[i]) bits_q[i] <= din;
    end
  end
endmodule

// File: rtl/olatch_drv.sv
module olatch_drv #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe,
  input  logic [NUM_CH-1:0] bits,
  output logic [NUM_CH-1:0] on_q,
  output logic [NUM_CH-1:0] off_n_q
);
  logic [NUM_CH-1:0] gated;
  assign gated = oe ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= '0;
      off_n_q <= '1;
    end else begin
      on_q    <= gated;
      off_n_q <= ~gated;
    end
  end
endmodule

// File: rtl/chan_out_latch.sv
module chan_out_latch
  import olatch_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = $clog2(NUM_CH),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              clr_n,
  input  logic              out_en,
  input  logic              wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] chan_on,
  output logic [NUM_CH-1:0] chan_off_n
);
  ctrl_t             ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [NUM_CH-1:0] sel_vec;
  logic [NUM_CH-1:0] bits_q;
  logic              clr_hist;
  logic              sel_n_s, clr_n_s, oe_s, din_s;

  assign ctl_raw = '{sel_n: sel_n, clr_n: clr_n, oe: out_en, din: wr_data};

  olatch_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  olatch_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL({ADDR_W{1'b1}})) u_sync_addr (
    .clk(clk), .rst(rst), .d(wr_addr), .q(addr_s)
  );

  assign sel_n_s = ctl_s.sel_n;
  assign clr_n_s = ctl_s.clr_n;
  assign oe_s    = ctl_s.oe;
  assign din_s   = ctl_s.din;

  olatch_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr_s), .en(!sel_n_s), .sel(sel_vec)
  );

  olatch_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .clr_n(clr_n_s), .din(din_s), .sel(sel_vec),
    .bits_q(bits_q), .clr_hist(clr_hist)
  );

  olatch_drv #(.NUM_CH(NUM_CH)) u_drv (
    .clk(clk), .rst(rst), .oe(oe_s), .bits(bits_q),
    .on_q(chan_on), .off_n_q(chan_off_n)
  );
endmodule

// File: rtl/olatch_chk.sv
module olatch_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n_s,
  input logic              clr_n_s,
  input logic              oe_s,
  input logic              din_s,
  input logic [ADDR_W-1:0] addr_s,
  input logic              clr_hist,
  input logic [NUM_CH-1:0] bits_q,
  input logic [NUM_CH-1:0] chan_on,
  input logic [NUM_CH-1:0] chan_off_n
);
  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    rst |=> (chan_on == '0 && chan_off_n == '1));

  // R10
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    chan_off_n == ~chan_on);

  // R6
  clear_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n_s |=> bits_q == '0);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n_s && clr_n_s) |=> $stable(bits_q));

  // R3
  write_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_s && clr_n_s && clr_hist) |=> bits_q[$past(addr_s)] == $past(din_s));

  // R5
  others_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_s && clr_n_s) |=>
      ((bits_q ^ $past(bits_q)) & ~(NUM_CH'(1) << $past(addr_s))) == '0);

  // R12
  release_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n_s && !clr_hist) |=> $stable(bits_q));

  // R7
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_s |=> chan_on == '0);
endmodule

bind chan_out_latch olatch_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n_s(sel_n_s), .clr_n_s(clr_n_s), .oe_s(oe_s),
  .din_s(din_s), .addr_s(addr_s), .clr_hist(clr_hist), .bits_q(bits_q),
  .chan_on(chan_on), .chan_off_n(chan_off_n)
);

// File: tb/chan_out_latch_tb.sv
module chan_out_latch_tb;
  localparam int N = 8;
  localparam int AW = 3;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, clr_n = 1'b1, out_en = 1'b0, wr_data = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [N-1:0] chan_on, chan_off_n;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_bits = '0;
  logic m_oe = 1'b0;

  always #5 clk = ~clk;

  chan_out_latch u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .clr_n(clr_n), .out_en(out_en),
    .wr_data(wr_data), .wr_addr(wr_addr), .chan_on(chan_on), .chan_off_n(chan_off_n)
  );

  function automatic logic [N-1:0] exp_on();
    return m_oe ? m_bits : '0;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive at a falling edge, hold until settled, update model, check
  task automatic step(logic s, logic c, logic o, logic d, logic [AW-1:0] a, string req);
    sel_n = s; clr_n = c; out_en = o; wr_data = d; wr_addr = a;
    if (!c) m_bits = '0;
    else if (!s) m_bits[a] = d;
    m_oe = o;
    edges(SETTLE);
    check(req, chan_on, exp_on());
    check("R10", chan_off_n, ~chan_on);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [AW-1:0] gray [N];
    logic [N-1:0] saved;
    gray = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd6, 3'd7, 3'd5, 3'd4};
    edges(3);
    check("R1", chan_on, '0);
    check("R1", chan_off_n, '1);
    @(negedge clk); rst = 1'b0;
    step(1, 1, 1, 0, 0, "R1");

    // R2: each code turns on exactly its own channel
    for (int k = 0; k < N; k++) begin
      step(0, 1, 1, 1, AW'(k), "R2");
      check("R2", chan_on, N'(1) << k);
      step(0, 1, 1, 0, AW'(k), "R2");
    end

    // R3: PWM on channel 4 while select held low
    for (int p = 0; p < 4; p++) step(0, 1, 1, p[0] ? 1'b0 : 1'b1, 3'd4, "R3");

    // R11: write latency
    step(1, 1, 1, 0, 3'd0, "R11");
    sel_n = 0; wr_addr = 3'd5; wr_data = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11", chan_on, '0);
    @(posedge clk); @(negedge clk);
    check("R11", chan_on, 8'h20);
    m_bits[5] = 1'b1;
    // R11: enable latency
    out_en = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11", chan_on, 8'h20);
    @(posedge clk); @(negedge clk);
    check("R11", chan_on, '0);
    step(1, 1, 1, 0, 3'd0, "R8");

    // R9: Gray sweep set then clear with select held low
    for (int k = 0; k < N; k++) step(0, 1, 1, 1, gray[k], "R9");
    check("R9", chan_on, '1);
    step(1, 1, 1, 1, 3'd0, "R4");
    // R4: address and data wiggle under high select
    step(1, 1, 1, 0, 3'd3, "R4");
    step(1, 1, 1, 0, 3'd6, "R4");
    check("R4", chan_on, '1);
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0, gray[k], "R9");
    check("R9", chan_on, 8'hF0);

    // R7: blanking keeps pattern
    saved = m_bits;
    step(1, 1, 0, 1, 3'd1, "R7");
    check("R7", chan_off_n, '1);
    step(1, 1, 1, 1, 3'd1, "R7");
    check("R7", chan_on, saved);

    // R6: clear beats a held write
    step(0, 0, 1, 1, 3'd2, "R6");
    check("R6", chan_on, '0);
    // R12: release cycle write skipped
    clr_n = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    check("R12", chan_on, '0);
    @(posedge clk); @(negedge clk);
    check("R12", chan_on, 8'h04);
    m_bits[2] = 1'b1;
    step(1, 1, 1, 0, 3'd0, "R12");

    // Random mix against the model (R3 R4 R5 R6 R8)
    void'($urandom(32'h5EED1234));
    for (int t = 0; t < 300; t++) begin
      logic s, c, o, d;
      logic [AW-1:0] a;
      s = ($urandom_range(0, 2) != 0) ? 1'b0 : 1'b1;
      c = ($urandom_range(0, 15) != 0);
      o = ($urandom_range(0, 7) != 0);
      d = 1'($urandom_range(0, 1));
      a = AW'($urandom_range(0, N - 1));
      step(s, c, o, d, a, "R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule